// File: doc/BRIEF.md
# E1 Clock-Slave Receive Output Port

This block drives one E1 channel's received bits onto a serial backplane pin at 2.048 Mb/s. The system side supplies the timing: a common clock shared by many channels and a common frame pulse. The channel follows that clock instead of its own recovered line clock. Every frame carries 32 time slots of 8 bits, sent most significant bit first. A per-channel frame pulse output marks the first bit of each frame.

The common clock runs either at the bit rate (1x) or at twice the bit rate (2x). In 2x mode each bit period holds two active clock edges. A configuration bit picks which of the two edges updates the data, frame-pulse and multi-function outputs. The common frame pulse is only ever sampled on the first edge of a bit period. A per-channel bit lets the channel ignore the common frame pulse, so that it keeps free-running frame timing.

The multi-function output has two modes. In reference mode it carries a reference clock. In external-signaling mode it carries the four signaling bits of each slot. The content to be sent is presented in parallel as a whole frame of slot bytes and slot signaling nibbles. Elastic buffering and slip control belong to the surrounding logic.

Top module: `e1_slave_rx_port`

## Requirements
- R1: While `rst_ni` is low, `rsd_o`, `rfp_o` and `aux_o` are 0. After reset the first edge of the common clock is a first edge. Without a frame pulse, the first bit sent is bit 0 of slot 0.
- R2: In 1x mode (`rate_2x_i`=0) every clock edge is the first edge of a new bit period. Each edge updates the outputs. The bit sent at position p (slot s = p/8, bit b = p%8) is `frame_data_i[8*s + 7 - b]`, so each slot byte goes out MSB first.
- R3: When `cfp_i` is high on a first edge and `fp_ignore_i` is 0, that bit period becomes bit 0 of slot 0. Counting then continues from there.
- R4: With `fp_ignore_i`=1, `cfp_i` has no effect. The position runs freely from 0 to 255 and wraps back to 0.
- R5: In 2x mode (`rate_2x_i`=1) edges alternate between first and second, starting with a first edge. The bit position advances only on first edges.
- R6: In 2x mode, outputs change only on first edges when `upd_second_i`=0. They change only on second edges when `upd_second_i`=1. On a second edge the value loaded is the position set on the preceding first edge.
- R7: In 2x mode, `cfp_i` high on a second edge is ignored, whatever the value of `upd_second_i`.
- R8: `rfp_o` is 1 exactly while the bit shown on `rsd_o` is bit 0 of slot 0.
- R9: With `sig_mode_i`=1, `aux_o` is 0 during bits 0 to 3 of a slot. During bits 4 to 7 it shows `frame_sig_i[4*s + 7 - b]`, so each nibble goes out MSB first. It updates on the same edges as `rsd_o`.
- R10: With `sig_mode_i`=0, `aux_o` is a reference clock. In 1x mode it toggles on every edge. In 2x mode it is 1 after a first edge and 0 after a second edge. It is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System common clock, 1x or 2x the bit rate |
| rst_ni | input | 1 | Synchronous active-low reset |
| rate_2x_i | input | 1 | 1 selects a double-rate common clock |
| upd_second_i | input | 1 | In 2x mode, 1 updates the outputs on the second edge |
| fp_ignore_i | input | 1 | 1 makes the channel ignore the common frame pulse |
| sig_mode_i | input | 1 | 1 puts signaling on `aux_o`, 0 a reference clock |
| cfp_i | input | 1 | Common frame pulse |
| frame_data_i | input | 256 | Slot bytes, slot s at bits [8s+7:8s] |
| frame_sig_i | input | 128 | Signaling nibbles, slot s at bits [4s+3:4s] |
| rsd_o | output | 1 | Serial receive data |
| rfp_o | output | 1 | Per-channel frame pulse |
| aux_o | output | 1 | Reference clock or signaling bits |

## Verification
The bench builds the block with its defaults: 32 slots of 8 bits and a 4-bit signaling nibble. One frame is therefore 256 bit periods, so a free run wraps within 256 cycles at 1x and within 512 cycles at 2x. That short frame lets the bench show the wrap at position 255 and many realignments by the common frame pulse. It also covers both update edges, and frame pulses placed on second edges, in one short run. The 4-of-8 signaling window puts the 0-to-signaling boundary inside every slot, so each slot exercises it.

// File: rtl/e1so_pkg.sv
// Shared configuration type for the E1 clock-slave receive output port.
// Assumes all configuration bits are quasi-static from the common clock's view.
package e1so_pkg;

    // Per-channel configuration, gathered from the top-level pins.
    typedef struct packed {
        logic rate_2x;     // common clock is twice the bit rate
        logic upd_second;  // in 2x mode update outputs on the second edge
        logic fp_ignore;   // ignore the common frame pulse
        logic sig_mode;    // multi-function output carries signaling
    } e1so_cfg_t;

endpackage

// File: rtl/e1so_timebase.sv
// Bit-period timing for one channel.
// It tracks which edge of a bit period the clock is on, and it counts
// the frame position. It also decides which edges update the outputs.
// Assumes the first clock edge after reset starts a bit period.
module e1so_timebase
    import e1so_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  e1so_cfg_t        cfg_i,
    input  logic             cfp_i,
    output logic             first_edge_o,
    output logic             upd_edge_o,
    output logic [POS_W-1:0] load_pos_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic             phase_q;  // 1: the next edge is the second of the bit period
    logic [POS_W-1:0] pos_q;    // position of the current bit period
    logic             take_fp;
    logic [POS_W-1:0] pos_adv;
    logic [POS_W-1:0] pos_d;

    // Classify the current edge, and choose the next position.
    always_comb begin
        first_edge_o = !cfg_i.rate_2x || !phase_q;
        take_fp      = first_edge_o && cfp_i && !cfg_i.fp_ignore;
        if (take_fp) begin
            pos_adv = '0;
        end else if (pos_q == LAST_POS) begin
            pos_adv = '0;
        end else begin
            pos_adv = pos_q + POS_W'(1);
        end
        pos_d        = first_edge_o ? pos_adv : pos_q;
        upd_edge_o   = !cfg_i.rate_2x || (phase_q == cfg_i.upd_second);
        load_pos_o   = pos_d;
    end

    // Alternate the phase in 2x mode. Hold it at "first" in 1x mode.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= cfg_i.rate_2x ? ~phase_q : 1'b0;
        end
    end

    // Advance or realign the frame position on first edges.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pos_q <= LAST_POS;
        end else begin
            pos_q <= pos_d;
        end
    end

endmodule

// File: rtl/e1so_bitsel.sv
// Chooses the data, signaling and frame-pulse bits for a frame position.
// The logic is purely combinational.
// Assumes the slot width and slot count are powers of two. The signaling
// nibble fills the last SIG_BITS bit times of each slot.
module e1so_bitsel #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    parameter int SIG_BITS  = 4,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int POS_W      = $clog2(FRAME_BITS),
    localparam int BIT_W      = $clog2(SLOT_BITS),
    localparam int SIG_W      = $clog2(SIG_BITS)
) (
    input  logic [POS_W-1:0]          pos_i,
    input  logic [FRAME_BITS-1:0]     frame_data_i,
    input  logic [SLOTS*SIG_BITS-1:0] frame_sig_i,
    output logic                      data_bit_o,
    output logic                      sig_bit_o,
    output logic                      fp_bit_o
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_BITS - 1);
    localparam logic [BIT_W-1:0] SIG_START = BIT_W'(SLOT_BITS - SIG_BITS);

    logic [SLOT_BITS-1:0] slot_bytes [SLOTS];
    logic [SIG_BITS-1:0]  slot_nibs  [SLOTS];
    logic [POS_W-BIT_W-1:0] slot_idx;
    logic [BIT_W-1:0]       bit_idx;
    logic [BIT_W-1:0]       msb_idx;
    logic [SIG_W-1:0]       sig_idx;
    logic [SLOT_BITS-1:0]   cur_byte;
    logic [SIG_BITS-1:0]    cur_nib;

    // Split the flat frame vectors into per-slot fields.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_bytes[s] = frame_data_i[s*SLOT_BITS +: SLOT_BITS];
        assign slot_nibs[s]  = frame_sig_i[s*SIG_BITS +: SIG_BITS];
    end

    // Select the slot and bit, MSB first, and gate signaling to its window.
    always_comb begin
        slot_idx   = pos_i[POS_W-1:BIT_W];
        bit_idx    = pos_i[BIT_W-1:0];
        msb_idx    = LAST_BIT - bit_idx;
        sig_idx    = SIG_W'(msb_idx);
        cur_byte   = slot_bytes[slot_idx];
        cur_nib    = slot_nibs[slot_idx];
        data_bit_o = cur_byte[msb_idx];
        sig_bit_o  = (bit_idx >= SIG_START) ? cur_nib[sig_idx] : 1'b0;
        fp_bit_o   = (pos_i == '0);
    end

endmodule

// File: rtl/e1so_outreg.sv
// Output registers for data, frame pulse and the multi-function pin.
// Data, frame pulse and signaling load only on update edges.
// The reference clock register steps on every edge.
// Assumes first_edge_i and upd_edge_i come from the timebase for this edge.
module e1so_outreg
    import e1so_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  e1so_cfg_t cfg_i,
    input  logic      first_edge_i,
    input  logic      upd_edge_i,
    input  logic      data_bit_i,
    input  logic      sig_bit_i,
    input  logic      fp_bit_i,
    output logic      rsd_o,
    output logic      rfp_o,
    output logic      aux_o
);

    logic rsd_q;
    logic rfp_q;
    logic sig_q;
    logic ref_q;

    // Load the selected bits on update edges only.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsd_q <= 1'b0;
            rfp_q <= 1'b0;
            sig_q <= 1'b0;
        end else if (upd_edge_i) begin
            rsd_q <= data_bit_i;
            rfp_q <= fp_bit_i;
            sig_q <= sig_bit_i;
        end
    end

    // Reference clock: toggles at 1x, and is high after first edges at 2x.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= cfg_i.rate_2x ? first_edge_i : ~ref_q;
        end
    end

    // Drive the pins. The multi-function pin follows the mode bit.
    always_comb begin
        rsd_o = rsd_q;
        rfp_o = rfp_q;
        aux_o = cfg_i.sig_mode ? sig_q : ref_q;
    end

endmodule

// File: rtl/e1_slave_rx_port.sv
// E1 clock-slave receive output port, top level.
// It serialises a presented frame onto the backplane, using the system
// common clock (1x or 2x) and the common frame pulse.
// Assumes frame_data_i and frame_sig_i are stable around each update edge.
module e1_slave_rx_port
    import e1so_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    parameter int SIG_BITS  = 4,
    localparam int FRAME_BITS = SLOTS * SLOT_BITS,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      rate_2x_i,
    input  logic                      upd_second_i,
    input  logic                      fp_ignore_i,
    input  logic                      sig_mode_i,
    input  logic                      cfp_i,
    input  logic [FRAME_BITS-1:0]     frame_data_i,
    input  logic [SLOTS*SIG_BITS-1:0] frame_sig_i,
    output logic                      rsd_o,
    output logic                      rfp_o,
    output logic                      aux_o
);

    e1so_cfg_t        cfg;
    logic             first_edge;
    logic             upd_edge;
    logic [POS_W-1:0] load_pos;
    logic             data_bit;
    logic             sig_bit;
    logic             fp_bit;

    // Gather the configuration pins into one struct.
    always_comb begin
        cfg.rate_2x    = rate_2x_i;
        cfg.upd_second = upd_second_i;
        cfg.fp_ignore  = fp_ignore_i;
        cfg.sig_mode   = sig_mode_i;
    end

    e1so_timebase #(
        .FRAME_BITS (FRAME_BITS)
    ) u_timebase (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_i        (cfg),
        .cfp_i        (cfp_i),
        .first_edge_o (first_edge),
        .upd_edge_o   (upd_edge),
        .load_pos_o   (load_pos)
    );

    e1so_bitsel #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .SIG_BITS  (SIG_BITS)
    ) u_bitsel (
        .pos_i        (load_pos),
        .frame_data_i (frame_data_i),
        .frame_sig_i  (frame_sig_i),
        .data_bit_o   (data_bit),
        .sig_bit_o    (sig_bit),
        .fp_bit_o     (fp_bit)
    );

    e1so_outreg u_outreg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_i        (cfg),
        .first_edge_i (first_edge),
        .upd_edge_i   (upd_edge),
        .data_bit_i   (data_bit),
        .sig_bit_i    (sig_bit),
        .fp_bit_i     (fp_bit),
        .rsd_o        (rsd_o),
        .rfp_o        (rfp_o),
        .aux_o        (aux_o)
    );

endmodule

// File: rtl/e1so_checker.sv
// Temporal checks for the E1 clock-slave receive output port.
// The checker is bound into the top module and watches its pins and its
// edge classification.
module e1so_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic rate_2x_i,
    input logic upd_second_i,
    input logic fp_ignore_i,
    input logic sig_mode_i,
    input logic cfp_i,
    input logic first_edge,
    input logic rsd_o,
    input logic rfp_o,
    input logic aux_o
);

    // R6: first-edge updates leave the outputs still on second edges.
    p_hold_on_second_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_2x_i && !upd_second_i && !first_edge) |=> ($stable(rsd_o) && $stable(rfp_o)));

    // R6: second-edge updates leave the outputs still on first edges.
    p_hold_on_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_2x_i && upd_second_i && first_edge) |=> ($stable(rsd_o) && $stable(rfp_o)));

    // R3: at 1x an honoured frame pulse shows bit 0 of slot 0 right away.
    p_fp_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rate_2x_i && cfp_i && !fp_ignore_i) |=> rfp_o);

    // R8: at 1x without realignment the frame pulse lasts one bit.
    p_fp_one_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rate_2x_i && rfp_o && !(cfp_i && !fp_ignore_i)) |=> !rfp_o);

    // R9: signaling is 0 during bit 0 of slot 0.
    p_sig_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sig_mode_i && rfp_o) |-> !aux_o);

    // R10: at 1x the reference clock toggles on every edge.
    p_ref_toggle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sig_mode_i && !rate_2x_i) |=> (sig_mode_i || (aux_o != $past(aux_o))));

endmodule

bind e1_slave_rx_port e1so_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rate_2x_i    (rate_2x_i),
    .upd_second_i (upd_second_i),
    .fp_ignore_i  (fp_ignore_i),
    .sig_mode_i   (sig_mode_i),
    .cfp_i        (cfp_i),
    .first_edge   (first_edge),
    .rsd_o        (rsd_o),
    .rfp_o        (rfp_o),
    .aux_o        (aux_o)
);

// File: tb/e1_slave_rx_port_bench.sv
// Self-checking bench: a bit-period model written from the requirements,
// driven by seeded random and directed stimulus.
module e1_slave_rx_port_bench;

    localparam int SLOTS = 32;
    localparam int SB    = 8;
    localparam int NB    = 4;
    localparam int FB    = SLOTS * SB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_2x = 1'b0, upd_second = 1'b0, fp_ignore = 1'b0, sig_mode = 1'b0, cfp = 1'b0;
    logic [FB-1:0]       fdata = '0;
    logic [SLOTS*NB-1:0] fsig  = '0;
    logic rsd, rfp, aux;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state.
    bit m_phase;   // 1: next edge is a second edge
    int m_pos;
    bit m_rsd, m_rfp, m_sig, m_ref;

    always #4 clk = ~clk;

    e1_slave_rx_port u_e1_slave_rx_port (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rate_2x_i    (rate_2x),
        .upd_second_i (upd_second),
        .fp_ignore_i  (fp_ignore),
        .sig_mode_i   (sig_mode),
        .cfp_i        (cfp),
        .frame_data_i (fdata),
        .frame_sig_i  (fsig),
        .rsd_o        (rsd),
        .rfp_o        (rfp),
        .aux_o        (aux)
    );

    function automatic bit exp_data(int pos);
        return fdata[(pos / SB) * SB + (SB - 1 - pos % SB)];
    endfunction

    function automatic bit exp_sig(int pos);
        int b = pos % SB;
        if (b < SB - NB) return 1'b0;
        return fsig[(pos / SB) * NB + (SB - 1 - b)];
    endfunction

    task automatic check(string tag, logic act, bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_phase = 1'b0; m_pos = FB - 1;
        m_rsd = 1'b0; m_rfp = 1'b0; m_sig = 1'b0; m_ref = 1'b0;
    endtask

    // One clock edge: update the model from the driven inputs, then compare at the negedge.
    task automatic step(string tag_d);
        bit first = !rate_2x || !m_phase;
        bit upd   = !rate_2x || (m_phase == upd_second);
        if (first) m_pos = (cfp && !fp_ignore) ? 0 : (m_pos + 1) % FB;
        if (upd) begin
            m_rsd = exp_data(m_pos);
            m_rfp = (m_pos == 0);
            m_sig = exp_sig(m_pos);
        end
        m_ref   = rate_2x ? first : !m_ref;
        m_phase = rate_2x ? !m_phase : 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(tag_d, rsd, m_rsd);
        check("R8", rfp, m_rfp);
        check(sig_mode ? "R9" : "R10", aux, sig_mode ? m_sig : m_ref);
    endtask

    task automatic new_frame();
        for (int i = 0; i < FB / 32; i++) fdata[i*32 +: 32] = $urandom;
        for (int i = 0; i < SLOTS * NB / 32; i++) fsig[i*32 +: 32] = $urandom;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_e1a0));
        new_frame();
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", rsd, 1'b0);
        check("R1", rfp, 1'b0);
        check("R1", aux, 1'b0);
        model_reset();
        rst_n = 1'b1;

        // R4 / R1: free run from reset with the frame pulse ignored; wraps past 255.
        fp_ignore = 1'b1; sig_mode = 1'b1;
        for (int i = 0; i < 600; i++) begin
            cfp = ($urandom % 7) == 0;
            step(i < 8 ? "R1" : "R4");
        end

        // R2: 1x, frame pulse honoured but absent, reference mode.
        fp_ignore = 1'b0; sig_mode = 1'b0; cfp = 1'b0; new_frame();
        for (int i = 0; i < 300; i++) step("R2");

        // R3: directed and random realignments at 1x.
        for (int i = 0; i < 500; i++) begin
            cfp = (i == 5) || (i == 6) || (($urandom % 90) == 0);
            step("R3");
        end
        cfp = 1'b0;

        // R5: 2x, first-edge update, no pulse.
        rate_2x = 1'b1; upd_second = 1'b0; sig_mode = 1'b1; new_frame();
        for (int i = 0; i < 700; i++) step("R5");

        // R6: 2x, second-edge update, pulses on first edges.
        upd_second = 1'b1;
        for (int i = 0; i < 700; i++) begin
            cfp = !m_phase && (($urandom % 60) == 0);
            step("R6");
        end

        // R7: pulses on second edges only must be ignored.
        for (int i = 0; i < 600; i++) begin
            upd_second = (i >= 300);
            sig_mode   = (i % 200) < 100;
            cfp = m_phase && (($urandom % 3) == 0);
            step("R7");
        end
        cfp = 1'b0;

        // Mixed random configuration.
        for (int blk = 0; blk < 20; blk++) begin
            rate_2x    = $urandom % 2;
            upd_second = $urandom % 2;
            fp_ignore  = ($urandom % 4) == 0;
            sig_mode   = $urandom % 2;
            new_frame();
            for (int i = 0; i < 100; i++) begin
                cfp = ($urandom % 50) == 0;
                step(rate_2x ? "R6" : "R2");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule